// File: doc/BRIEF.md
# Steered Processor Watchdog

This block watches a host processor for signs of life. Software programs a single 8-bit configuration register with a multiplier, a resolution code and a steering bit. The block then counts timebase strobes until it reaches the product of multiplier and resolution. Each read or write of the configuration register by the host starts the period again. If the period runs out, the block raises a watchdog flag. The steering bit then decides what else happens: either an interrupt line is latched, or a reset pulse of fixed width is driven toward the processor.

The timebase arrives as a one-cycle strobe at 16 Hz, so one strobe is 1/16 s. The interrupt line is shared with a frequency-test square wave that a neighbouring block supplies. The watchdog takes the line whenever it is armed and steered to interrupt. A timeout steered to reset empties the configuration register when its pulse finishes. It also sends a one-cycle request to clear the neighbour's frequency-test enable. The reset is synchronous and active high.

Top module: `steered_watchdog`

## Requirements
- R1: After reset the configuration register reads 00h and wd_flag, irq_line (with ftest_en low), wd_reset and ftest_clr are all 0.
- R2: The configuration register holds the steering bit in bit 7, the multiplier M in bits 6..2 and the resolution code in bits 1..0. The codes 00, 01, 10 and 11 give 1, 4, 16 and 64 strobes. A timeout happens on the (M × resolution)-th tick16 strobe counted after the last restart. wd_flag is high in the cycle after the edge that samples that strobe.
- R3: A host read (reg_rd) or write (reg_wr) of the configuration register restarts the count from zero.
- R4: When M is 0, no timeout is ever produced, whatever the resolution bits hold. This includes the value 00h.
- R5: With bit 7 at 0, a timeout sets wd_flag and drives irq_line high. Both stay high until flag_rd, reg_rd or reg_wr is applied. A clear arrives in the cycle after that access edge.
- R6: With bit 7 at 1, a timeout sets wd_flag and drives wd_reset high for exactly PULSE_CYCLES clock cycles. The watchdog does not raise irq_line for this timeout.
- R7: On the edge that ends the reset pulse, the configuration register is cleared to 00h and ftest_clr is high for exactly one cycle.
- R8: While the reset pulse is active, tick16 strobes neither lengthen the pulse nor start a new timeout.
- R9: When bit 7 is 0 and M is nonzero, irq_line carries only the watchdog interrupt and the frequency-test wave is blocked. Otherwise irq_line equals ftest_en AND ftest_wave.
- R10: A register access in the same cycle as the final strobe wins over it, so no timeout occurs. A flag_rd in the same cycle as a timeout leaves wd_flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle timebase strobe, 16 per second |
| reg_wr | input | 1 | Host write of the configuration register |
| reg_wdata | input | 8 | Data for reg_wr |
| reg_rd | input | 1 | Host read of the configuration register |
| flag_rd | input | 1 | Host read of the watchdog flag |
| ftest_en | input | 1 | Frequency-test enable from the neighbour block |
| ftest_wave | input | 1 | Frequency-test square wave |
| reg_rdata | output | 8 | Current configuration register value |
| wd_flag | output | 1 | Watchdog timeout flag |
| irq_line | output | 1 | Shared interrupt / frequency-test line, active high |
| wd_reset | output | 1 | Reset pulse toward the processor, active high |
| ftest_clr | output | 1 | One-cycle request to clear the frequency-test enable |

## Verification
Two collisions need care. The first is a host register access in the same cycle as the strobe that would end the period. The second is a flag read in the same cycle as a timeout. The bench holds reg_rd high together with the final tick16 and expects wd_flag to stay low. It then expects a full new period before the flag rises. For the other case it holds flag_rd high with the expiring tick16 and expects wd_flag to remain set afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int CFG_W  = 1 + MULT_W + RES_W;
  // Largest resolution is 4**(2**RES_W - 1) strobes, i.e. a shift of 2*(2**RES_W-1)
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int LIM_W  = MULT_W + MAX_SHIFT;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdt_cfg_t;

  function automatic logic [LIM_W-1:0] period_ticks(input wdt_cfg_t c);
    logic [LIM_W-1:0] base;
    base = LIM_W'(c.mult);
    return base << (2 * c.res);
  endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             wipe,
  output wdt_cfg_t         cfg
);
  // Host write takes precedence over the end-of-pulse wipe
  always_ff @(posedge clk) begin
    if (rst)       cfg <= '0;
    else if (wr)   cfg <= wdt_cfg_t'(wdata);
    else if (wipe) cfg <= '0;
  end

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (wipe && !wr) |=> (cfg == '0)); // R7
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wdt_cfg_t cfg,
  input  logic     tick,
  input  logic     restart,
  input  logic     hold,
  output logic     expire
);
  logic [LIM_W-1:0] elapsed;
  logic [LIM_W-1:0] limit;
  logic             armed;

  assign limit  = period_ticks(cfg);
  assign armed  = (cfg.mult != '0);
  assign expire = armed && tick && !restart && !hold && (elapsed == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || !armed) elapsed <= '0;
    else if (hold)                elapsed <= elapsed;
    else if (expire)              elapsed <= '0;
    else if (tick)                elapsed <= elapsed + 1'b1;
  end

  AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cfg.mult == '0) |-> !expire); // R4
  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    armed |-> (limit != '0)); // R2
endmodule

// File: rtl/wdt_response.sv
module wdt_response #(
  parameter int PULSE_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic steer,
  input  logic ack,
  output logic flag_q,
  output logic irq_q,
  output logic busy,
  output logic pulse_end,
  output logic ftest_clr
);
  localparam int PC_W = $clog2(PULSE_CYCLES + 1);
  logic [PC_W-1:0] left;

  assign pulse_end = busy && (left == '0);

  // A new timeout sets the flag even when an acknowledge lands in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
      irq_q  <= !steer;
    end else if (ack) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      left      <= '0;
      ftest_clr <= 1'b0;
    end else begin
      ftest_clr <= pulse_end;
      if (expire && steer) begin
        busy <= 1'b1;
        left <= PC_W'(PULSE_CYCLES - 1);
      end else if (pulse_end) begin
        busy <= 1'b0;
      end else if (busy) begin
        left <= left - 1'b1;
      end
    end
  end

  AST_PULSE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq_q); // R6
  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q); // R5
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ftest_clr |=> !ftest_clr); // R7
endmodule

// File: rtl/steered_watchdog.sv
module steered_watchdog
  import wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 25_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             reg_wr,
  input  logic [CFG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  input  logic             flag_rd,
  input  logic             ftest_en,
  input  logic             ftest_wave,
  output logic [CFG_W-1:0] reg_rdata,
  output logic             wd_flag,
  output logic             irq_line,
  output logic             wd_reset,
  output logic             ftest_clr
);
  wdt_cfg_t cfg;
  logic     access, expire, busy, pulse_end, flag_q, irq_q, owns_line;

  assign access = reg_wr || reg_rd;

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .wipe(pulse_end), .cfg(cfg)
  );

  wdt_timer u_timer (
    .clk(clk), .rst(rst), .cfg(cfg), .tick(tick16),
    .restart(access), .hold(busy), .expire(expire)
  );

  wdt_response #(.PULSE_CYCLES(PULSE_CYCLES)) u_resp (
    .clk(clk), .rst(rst), .expire(expire), .steer(cfg.steer),
    .ack(access || flag_rd), .flag_q(flag_q), .irq_q(irq_q),
    .busy(busy), .pulse_end(pulse_end), .ftest_clr(ftest_clr)
  );

  assign owns_line = !cfg.steer && (cfg.mult != '0);
  assign irq_line  = owns_line ? irq_q : (ftest_en && ftest_wave);
  assign reg_rdata = cfg;
  assign wd_flag   = flag_q;
  assign wd_reset  = busy;

  AST_ACCESS_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
    (access && !busy) |=> !$rose(wd_reset)); // R10
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_reset) |-> wd_flag); // R6
endmodule

// File: tb/tb_steered_watchdog.sv
module tb_steered_watchdog;
  localparam int PULSE = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, flag_rd = 1'b0;
  logic       ftest_en = 1'b0, ftest_wave = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wd_flag, irq_line, wd_reset, ftest_clr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  steered_watchdog #(.PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst(rst), .tick16(tick16), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .flag_rd(flag_rd),
    .ftest_en(ftest_en), .ftest_wave(ftest_wave), .reg_rdata(reg_rdata),
    .wd_flag(wd_flag), .irq_line(irq_line), .wd_reset(wd_reset),
    .ftest_clr(ftest_clr)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic read_cfg();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic read_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick16 = 1'b1;
      @(negedge clk); tick16 = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 cfg", reg_rdata, 0);
    check("R1 flag", wd_flag, 0);
    check("R1 irq", irq_line, 0);
    check("R1 rst", wd_reset, 0);
    check("R1 fclr", ftest_clr, 0);
  endtask

  task automatic t_period(input logic [7:0] v, input int lim);
    write_cfg(v);
    ticks(lim - 1);
    check("R2 before", wd_flag, 0);
    ticks(1);
    check("R2 at limit", wd_flag, 1);
    check("R5 irq", irq_line, 1);
    read_flag();
    check("R5 flag cleared", wd_flag, 0);
    check("R5 irq cleared", irq_line, 0);
  endtask

  task automatic t_restart();
    write_cfg(8'h09);            // M=2, res 4 -> 8 strobes
    ticks(6);
    read_cfg();
    ticks(7);
    check("R3 read restarts", wd_flag, 0);
    ticks(1);
    check("R3 full period", wd_flag, 1);
    ticks(2);
    write_cfg(8'h09);            // write acknowledges and restarts
    check("R5 write clears", wd_flag, 0);
    ticks(7);
    check("R3 write restarts", wd_flag, 0);
    read_cfg();
    check("R5 read clears", wd_flag, 0);
  endtask

  task automatic t_disabled();
    write_cfg(8'h03);            // M=0, res 11
    ticks(200);
    check("R4 M zero", wd_flag, 0);
    write_cfg(8'h00);
    ticks(100);
    check("R4 00h", wd_flag, 0);
  endtask

  task automatic t_collide();
    write_cfg(8'h05);            // M=1, res 4
    ticks(3);
    @(negedge clk); tick16 = 1'b1; reg_rd = 1'b1;
    @(negedge clk); tick16 = 1'b0; reg_rd = 1'b0;
    check("R10 access wins", wd_flag, 0);
    ticks(3);
    check("R10 new period", wd_flag, 0);
    @(negedge clk); tick16 = 1'b1; flag_rd = 1'b1;
    @(negedge clk); tick16 = 1'b0; flag_rd = 1'b0;
    check("R10 set beats flag read", wd_flag, 1);
    read_flag();
  endtask

  task automatic t_pulse();
    int hi_rst, hi_clr;
    hi_rst = 0; hi_clr = 0;
    write_cfg(8'h85);            // steer reset, M=1, res 4
    ticks(4);
    check("R6 flag", wd_flag, 1);
    check("R6 no irq", irq_line, 0);
    // keep strobing during the pulse
    for (int i = 0; i < PULSE + 10; i++) begin
      if (wd_reset) hi_rst++;
      if (ftest_clr) hi_clr++;
      if (wd_reset) check("R6 irq low in pulse", irq_line, 0);
      @(negedge clk); tick16 = ~tick16;
    end
    tick16 = 1'b0;
    check("R6 width", hi_rst, PULSE);
    check("R8 no retrigger", wd_reset, 0);
    check("R7 fclr once", hi_clr, 1);
    check("R7 cfg wiped", reg_rdata, 0);
    read_flag();
  endtask

  task automatic t_ftest();
    ftest_en = 1'b1; ftest_wave = 1'b1;
    write_cfg(8'h05);
    check("R9 ft blocked", irq_line, 0);
    write_cfg(8'h00);
    check("R9 ft passes disabled", irq_line, 1);
    write_cfg(8'h84);
    check("R9 ft passes steer", irq_line, 1);
    ftest_wave = 1'b0; #1;
    check("R9 ft follows wave", irq_line, 0);
    ftest_en = 1'b0;
    write_cfg(8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_period(8'h05, 4);
        t_period(8'h0E, 48);
        t_period(8'h07, 64);
        t_period(8'h04, 1);
        t_restart();
        t_disabled();
        t_collide();
        t_pulse();
        t_ftest();
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule